// File: doc/BRIEF.md
# Memory Read-Modify-Write Operation Unit

This unit carries out one operation whose destination is memory. It takes a request holding an address, a register value, a four-bit operation code and a destination register. It reads the addressed word through a single-port synchronous memory interface and combines that word with the register value. It then writes the result back to the same address. The operation set follows the style of memory-destination arithmetic: plain store, exchange, add, subtract in either order, AND, OR and XOR.

One read-compute-write path serves two uses. When the request names the zero register as its destination, the operation is a store to memory and no register is updated. For any other destination, the word read before modification is returned in a response pulse so that the register file can take it. An exchange stores the register value and returns the previous memory word.

The top bit of the operation code marks the access as non-cacheable. That attribute is driven on both the read and the write and is held for the whole request. The unit accepts one request at a time and keeps its ready signal low until the request has finished.

Top module: `mem_rmw_unit`

## Requirements
- R1: `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for the following cycles of that request and returns high in the first idle cycle.
- R2: For an operation whose low three op bits are not 0, the memory read is issued in the cycle after acceptance (`mem_req`=1, `mem_we`=0, `mem_addr` = request address). The next cycle has no memory access. The write to the same address is issued in the third cycle after acceptance.
- R3: A move (op bits [2:0] = 0, codes 0 and 8) issues no read. It issues its write in the cycle after acceptance, and the written data is the register value.
- R4: The data written for op bits [2:0] is: 1 = register value (exchange), 2 = memory + register, 3 = memory − register, 4 = register − memory, 5 = AND, 6 = OR, 7 = XOR. Arithmetic wraps modulo 2^DATA_W.
- R5: Op bit 3 leaves the operation unchanged. When it is set, `mem_nc` is high in every cycle from acceptance until the unit is idle again, covering both the read and the write. `mem_nc` is low whenever the unit is idle.
- R6: `rsp_valid` is a one-cycle pulse raised in exactly the cycle the memory write is issued. `rsp_dst` carries the request's destination index. `rsp_data` carries the memory word read before modification, or the register value for a move.
- R7: `rsp_wen` equals the inverse of the request's zero-destination flag. The response pulse and the memory write occur in both cases.
- R8: While reset is asserted and immediately after it, `req_ready` is 1 and `mem_req`, `rsp_valid` and `mem_nc` are 0.
- R9: Request inputs presented while a request is in progress are ignored. The address, write data and response of the running request are unchanged, and no other memory word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | ADDR_W | Memory word address |
| req_data | input | DATA_W | Register operand |
| req_op | input | 4 | Operation code; bit 3 is the non-cacheable marker |
| req_dst | input | IDX_W | Destination register index |
| req_dst_zero | input | 1 | Destination is the zero register |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read |
| mem_nc | output | 1 | Non-cacheable attribute |
| rsp_valid | output | 1 | Response pulse |
| rsp_wen | output | 1 | Register writeback enable |
| rsp_dst | output | IDX_W | Destination register index |
| rsp_data | output | DATA_W | Value for the destination register |

## Verification
The hardest case to reach from the ports is a new request arriving while the unit is busy. It only matters if the unit wrongly takes it, and that would show up as a corrupted address or write data, or as a second word being written. The stimulus therefore keeps `req_valid` high with a different address, operand and op code through the read, wait and write cycles of a running request. It then checks the running request's memory signals and the untouched neighbouring word. Carry and borrow wrap at the word boundaries are reached by preloading all-ones and zero memory words.

// File: rtl/rmw_pkg.sv
// Shared types for the read-modify-write unit.
// Assumes op codes use three function bits plus one attribute bit.
package rmw_pkg;

    typedef enum logic [2:0] {
        FN_MOV  = 3'd0,
        FN_XCHG = 3'd1,
        FN_ADD  = 3'd2,
        FN_SUBM = 3'd3,   // memory minus register
        FN_SUBR = 3'd4,   // register minus memory
        FN_AND  = 3'd5,
        FN_OR   = 3'd6,
        FN_XOR  = 3'd7
    } rmw_fn_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } rmw_state_e;

endpackage

// File: rtl/rmw_alu.sv
// Combines the old memory word with the register operand.
// Assumes both operands are held stable by the caller; purely combinational.
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  rmw_fn_e             fn,
    input  logic [DATA_W-1:0]   mem_val,
    input  logic [DATA_W-1:0]   reg_val,
    output logic [DATA_W-1:0]   result
);

    // Select the new memory word for the requested function.
    always_comb begin
        unique case (fn)
            FN_MOV,
            FN_XCHG: result = reg_val;
            FN_ADD:  result = mem_val + reg_val;
            FN_SUBM: result = mem_val - reg_val;
            FN_SUBR: result = reg_val - mem_val;
            FN_AND:  result = mem_val & reg_val;
            FN_OR:   result = mem_val | reg_val;
            FN_XOR:  result = mem_val ^ reg_val;
            default: result = reg_val;
        endcase
    end

endmodule

// File: rtl/rmw_seq.sv
// Request sequencer: idle, read, wait for data, write with response, done.
// Assumes memory returns read data one cycle after the read is issued.
module rmw_seq
    import rmw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_is_move,
    output logic        accept,
    output logic        capture_old,
    output rmw_state_e  state
);

    rmw_state_e state_q, state_d;

    assign accept      = req_valid && (state_q == ST_IDLE);
    assign capture_old = (state_q == ST_WAIT);
    assign state       = state_q;

    // Next-state selection; a move goes straight to the write.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = req_is_move ? ST_WRITE : ST_READ;
            ST_READ:  state_d = ST_WAIT;
            ST_WAIT:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/rmw_hold.sv
// Holds the accepted request and the old memory word for the running operation.
// Assumes accept and capture_old are never high in the same cycle.
module rmw_hold #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture_old,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [3:0]        in_op,
    input  logic [IDX_W-1:0]  in_dst,
    input  logic              in_dst_zero,
    input  logic [DATA_W-1:0] in_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic [3:0]        op_q,
    output logic [IDX_W-1:0]  dst_q,
    output logic              dst_zero_q,
    output logic [DATA_W-1:0] old_q
);

    // Capture request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            data_q     <= '0;
            op_q       <= '0;
            dst_q      <= '0;
            dst_zero_q <= 1'b1;
        end else if (accept) begin
            addr_q     <= in_addr;
            data_q     <= in_data;
            op_q       <= in_op;
            dst_q      <= in_dst;
            dst_zero_q <= in_dst_zero;
        end
    end

    // Capture the memory word in the cycle its read data is valid.
    always_ff @(posedge clk) begin
        if (!rst_n)           old_q <= '0;
        else if (capture_old) old_q <= in_rdata;
    end

endmodule

// File: rtl/mem_rmw_unit.sv
// Top of the memory read-modify-write unit. One request at a time.
// Assumes a single-port synchronous memory with one cycle of read latency.
module mem_rmw_unit
    import rmw_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [3:0]        req_op,
    input  logic [IDX_W-1:0]  req_dst,
    input  logic              req_dst_zero,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_nc,
    output logic              rsp_valid,
    output logic              rsp_wen,
    output logic [IDX_W-1:0]  rsp_dst,
    output logic [DATA_W-1:0] rsp_data
);

    localparam int FN_W = 3;

    rmw_state_e        state;
    logic              accept, capture_old;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q, old_q, alu_out;
    logic [3:0]        op_q;
    logic [IDX_W-1:0]  dst_q;
    logic              dst_zero_q;
    logic              held_move;
    rmw_fn_e           held_fn;

    assign held_fn   = rmw_fn_e'(op_q[FN_W-1:0]);
    assign held_move = (held_fn == FN_MOV);

    rmw_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_is_move (req_op[FN_W-1:0] == FN_MOV),
        .accept      (accept),
        .capture_old (capture_old),
        .state       (state)
    );

    rmw_hold #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .capture_old (capture_old),
        .in_addr     (req_addr),
        .in_data     (req_data),
        .in_op       (req_op),
        .in_dst      (req_dst),
        .in_dst_zero (req_dst_zero),
        .in_rdata    (mem_rdata),
        .addr_q      (addr_q),
        .data_q      (data_q),
        .op_q        (op_q),
        .dst_q       (dst_q),
        .dst_zero_q  (dst_zero_q),
        .old_q       (old_q)
    );

    rmw_alu #(.DATA_W(DATA_W)) u_alu (
        .fn      (held_fn),
        .mem_val (old_q),
        .reg_val (data_q),
        .result  (alu_out)
    );

    // Handshake and memory-side outputs decoded from the state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_addr  = addr_q;
        mem_wdata = alu_out;
        mem_nc    = (state != ST_IDLE) && op_q[3];
    end

    // Response pulse issued alongside the write.
    always_comb begin
        rsp_valid = (state == ST_WRITE);
        rsp_wen   = (state == ST_WRITE) && !dst_zero_q;
        rsp_dst   = dst_q;
        rsp_data  = held_move ? data_q : old_q;
    end

endmodule

// File: rtl/mem_rmw_unit_chk.sv
// Port-level protocol checker for mem_rmw_unit, attached with bind.
module mem_rmw_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic mem_req,
    input logic mem_we,
    input logic mem_nc,
    input logic rsp_valid
);

    AST_ACCEPT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R1
    AST_BUSY_AT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R1
    AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req); // R2
    AST_RSP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_req && mem_we)); // R6
    AST_WRITE_HAS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> rsp_valid); // R6
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R6
    AST_NC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_nc); // R5
    AST_NC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(mem_nc)); // R5

endmodule

bind mem_rmw_unit mem_rmw_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_nc    (mem_nc),
    .rsp_valid (rsp_valid)
);

// File: tb/mem_rmw_unit_test.sv
// Bench for mem_rmw_unit: behavioural memory plus a per-cycle expected trace.
module mem_rmw_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [63:0] req_data = '0;
    logic [3:0]  req_op = '0;
    logic [5:0]  req_dst = '0;
    logic        req_dst_zero = 1'b0;
    logic        mem_req, mem_we, mem_nc;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        rsp_valid, rsp_wen;
    logic [5:0]  rsp_dst;
    logic [63:0] rsp_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [63:0] mem [16];

    always #5 clk = ~clk;

    mem_rmw_unit uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_op(req_op),
        .req_dst(req_dst), .req_dst_zero(req_dst_zero),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_nc(mem_nc),
        .rsp_valid(rsp_valid), .rsp_wen(rsp_wen), .rsp_dst(rsp_dst),
        .rsp_data(rsp_data)
    );

    // Behavioural single-port memory, one cycle of read latency.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[3:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[3:0]];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [63:0] model(input logic [63:0] m, input logic [63:0] r, input logic [2:0] f);
        case (f)
            3'd0, 3'd1: return r;
            3'd2: return m + r;
            3'd3: return m - r;
            3'd4: return r - m;
            3'd5: return m & r;
            3'd6: return m | r;
            default: return m ^ r;
        endcase
    endfunction

    // Runs one request and compares every cycle against the expected trace.
    task automatic run_op(input logic [31:0] a, input logic [63:0] d, input logic [3:0] op,
                          input logic [5:0] dst, input logic dz, input bit hold);
        logic [63:0] old_w, res, other_w;
        logic [31:0] junk_a;
        bit mv;
        int n, wr_c;
        junk_a  = a ^ 32'd1;
        old_w   = mem[a[3:0]];
        other_w = mem[junk_a[3:0]];
        mv      = (op[2:0] == 3'd0);
        res     = model(old_w, d, op[2:0]);
        n       = mv ? 3 : 5;
        wr_c    = mv ? 1 : 3;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d; req_op = op;
        req_dst = dst; req_dst_zero = dz;
        chk(req_ready == 1'b1, "R1 ready idle", 64'(req_ready), 64'd1);
        @(posedge clk);
        #1;
        if (hold) begin
            req_addr = junk_a; req_data = ~d; req_op = op ^ 4'd5; req_dst = ~dst;
        end else begin
            req_valid = 1'b0;
        end
        for (int c = 1; c <= n; c++) begin
            bit rd, wr, busy;
            @(negedge clk);
            rd = !mv && (c == 1);
            wr = (c == wr_c);
            busy = (c < n);
            chk(mem_req == (rd || wr), mv ? "R3 access pattern" : "R2 access pattern",
                64'(mem_req), 64'(rd || wr));
            if (rd) begin
                chk(!mem_we, "R2 read phase", 64'(mem_we), 64'd0);
                chk(mem_addr == a, "R2 read addr R9", 64'(mem_addr), 64'(a));
            end
            if (wr) begin
                chk(mem_we, "R2 write phase", 64'(mem_we), 64'd1);
                chk(mem_addr == a, "R2 write addr R9", 64'(mem_addr), 64'(a));
                chk(mem_wdata == res, "R4 write data", mem_wdata, res);
                chk(rsp_valid, "R6 rsp with write", 64'(rsp_valid), 64'd1);
                chk(rsp_wen == !dz, "R7 writeback enable", 64'(rsp_wen), 64'(!dz));
                chk(rsp_dst == dst, "R6 rsp dst", 64'(rsp_dst), 64'(dst));
                chk(rsp_data == (mv ? d : old_w), "R6 rsp data", rsp_data, mv ? d : old_w);
            end else begin
                chk(!rsp_valid, "R6 rsp pulse only", 64'(rsp_valid), 64'd0);
            end
            chk(req_ready == !busy, "R1 ready lockout", 64'(req_ready), 64'(!busy));
            chk(mem_nc == (busy && op[3]), "R5 nc attribute", 64'(mem_nc), 64'(busy && op[3]));
            if (c == n - 1) req_valid = 1'b0;
        end
        chk(mem[a[3:0]] == res, "R4 memory result", mem[a[3:0]], res);
        if (hold)
            chk(mem[junk_a[3:0]] == other_w, "R9 no stray write", mem[junk_a[3:0]], other_w);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 64'h1111_0000_0000_0000 * 64'(i) + 64'(i * 7 + 3);
        mem[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        mem[4] = 64'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 reset state
        chk(req_ready == 1'b1, "R8 ready in reset", 64'(req_ready), 64'd1);
        chk(!mem_req, "R8 no access in reset", 64'(mem_req), 64'd0);
        chk(!rsp_valid, "R8 no rsp in reset", 64'(rsp_valid), 64'd0);
        chk(!mem_nc, "R8 nc low in reset", 64'(mem_nc), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req && !mem_nc, "R8 idle after reset", 64'(req_ready), 64'd1);

        run_op(32'd1, 64'hDEAD_BEEF_0000_0001, 4'd0, 6'd5,  1'b0, 1'b0); // R3 move
        run_op(32'd3, 64'h0123_4567_89AB_CDEF, 4'd1, 6'd7,  1'b0, 1'b0); // R4 exchange
        run_op(32'd2, 64'd1,                   4'd2, 6'd9,  1'b0, 1'b0); // R4 add wrap
        run_op(32'd4, 64'd1,                   4'd3, 6'd10, 1'b0, 1'b0); // R4 mem-reg borrow
        run_op(32'd5, 64'd100,                 4'd4, 6'd11, 1'b0, 1'b0); // R4 reg-mem
        run_op(32'd6, 64'hF0F0_F0F0_F0F0_F0F0, 4'd5, 6'd12, 1'b0, 1'b0); // R4 and
        run_op(32'd7, 64'h0F0F_0000_0000_0F0F, 4'd6, 6'd13, 1'b0, 1'b0); // R4 or
        run_op(32'd8, 64'hFFFF_0000_FFFF_0000, 4'd7, 6'd14, 1'b0, 1'b0); // R4 xor
        run_op(32'd9, 64'd55,                  4'd10, 6'd20, 1'b0, 1'b0); // R5 nc add
        run_op(32'd10, 64'hAAAA,               4'd8, 6'd21, 1'b1, 1'b0); // R5 nc move, R7 zero dst
        run_op(32'd11, 64'h5555,               4'd9, 6'd22, 1'b1, 1'b0); // R7 exchange to zero
        run_op(32'd12, 64'd3,                  4'd12, 6'd23, 1'b0, 1'b1); // R9 busy inputs
        run_op(32'd14, 64'h77,                 4'd0, 6'd24, 1'b0, 1'b1); // R9 during move
        run_op(32'd12, 64'h1234,               4'd15, 6'd25, 1'b1, 1'b1); // R5 R9 nc xor

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule